// File: doc/BRIEF.md
# Serial Port Register Front End with FIFO Interrupts

This block is the software-facing side of a serial port. A simple 32-bit bus with separate read and write strobes and byte-offset word addresses reaches six registers:

- a transmit data port;
- a receive data port;
- a control word;
- a status word;
- a threshold word;
- a baud word.

Two FIFOs of parameterised depth (64 entries by default) sit behind the data ports. The transmit FIFO feeds a bit serializer through a valid/ready byte port. The receive FIFO is filled by a deserializer through the same kind of port. The serializer, the deserializer and the baud generator live outside this block. They read their settings from the control and baud words, which the block drives out.

A single level-sensitive interrupt line is raised from two sources, each with its own enable bit and its own threshold field. The first source fires when the receive FIFO fill reaches its threshold. The second fires when the transmit FIFO fill drops below its threshold.

Error flags are sticky:

- parity and framing pulses come from the receiver;
- a write-overflow flag is set locally.

The error-clear bit and the two FIFO-flush bits are ordinary stored bits. Each acts for as long as it holds 1, so software writes 1 and then writes 0 again.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the status word at offset 0x0C reads 0x0050_0000 (receive-empty bit 20 and transmit-empty bit 22 set). The control word (0x08), threshold word (0x10) and baud word (0x14) read 0, and irq is 0.
- R2: The control and baud words read back the full 32-bit value last written, and drive the cfg_ctrl and cfg_baud outputs. The threshold word keeps bits 15:0 and reads 0 in bits 31:16. Reads of unmapped offsets return 0.
- R3: Bytes written to bits 7:0 of offset 0x00 leave on tx_data in write order. A byte is handed over on a cycle where tx_valid and tx_ready are both 1. tx_valid stays 0 while control bit 12 (transmit enable) is 0.
- R4: With the transmit FIFO full (status bit 21 = 1), a write to 0x00 is discarded and sets sticky status bit 18. The stored bytes are unchanged.
- R5: While control bit 13 (receive enable) is 1 and the receive FIFO is not full, rx_ready is 1 and rx_valid stores rx_data. A read of 0x04 returns the oldest byte in bits 7:0 and removes it. A read of 0x04 while the FIFO is empty returns 0 and leaves status bit 20 set.
- R6: A one-cycle pulse on par_err_in or frm_err_in sets status bit 16 or bit 17, which then stays set. While control bit 24 is 1, bits 16, 17 and 18 read 0, even when new errors arrive. Once bit 24 returns to 0, new errors set the flags again.
- R7: While control bit 22 (or bit 23) is 1, the transmit (or receive) FIFO is held empty and accepts nothing. Once the bit returns to 0, the FIFO works normally.
- R8: irq includes the receive source, which is 1 while control bit 27 is 1 and the receive fill is at or above threshold bits 7:0.
- R9: irq includes the transmit source, which is 1 while control bit 28 is 1 and the transmit fill is below threshold bits 15:8.
- R10: Status bit 25 mirrors the tx_busy input. The transmit path is drained when bit 22 is 1 and bit 25 is 0.
- R11: When a push and a pop hit the same FIFO in one cycle, the fill does not change and byte order is preserved. This holds for a bus write with a serializer take on the transmit side, and for a deserializer store with a bus read on the receive side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_busy | input | 1 | Serializer is shifting a byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive FIFO can store a byte |
| par_err_in | input | 1 | Parity error pulse |
| frm_err_in | input | 1 | Framing error pulse |
| cfg_ctrl | output | 32 | Current control word |
| cfg_baud | output | 32 | Current baud word |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can fall in the same cycle. On the transmit side, the serializer can take the head byte in the same cycle that software writes a new byte. On the receive side, the deserializer can store a byte in the same cycle that software reads the head.

The bench drives both strobes on one clock edge, with the FIFO holding one or two entries. It then drains the FIFO and checks that each byte appears exactly once and in order, and that the empty flag rises exactly after the last byte.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   // register offsets (byte addresses of 32-bit words)
   localparam int OFS_TXD  = 'h00;
   localparam int OFS_RXD  = 'h04;
   localparam int OFS_CTRL = 'h08;
   localparam int OFS_STAT = 'h0C;
   localparam int OFS_THR  = 'h10;
   localparam int OFS_BAUD = 'h14;

   // control bits
   localparam int C_TX_EN    = 12;
   localparam int C_RX_EN    = 13;
   localparam int C_TX_FLUSH = 22;
   localparam int C_RX_FLUSH = 23;
   localparam int C_ERR_CLR  = 24;
   localparam int C_RX_IE    = 27;
   localparam int C_TX_IE    = 28;

   // status bits
   localparam int S_PAR      = 16;
   localparam int S_FRM      = 17;
   localparam int S_WERR     = 18;
   localparam int S_RX_EMPTY = 20;
   localparam int S_TX_FULL  = 21;
   localparam int S_TX_EMPTY = 22;
   localparam int S_BUSY     = 25;

   typedef struct packed {
      logic par;
      logic frm;
      logic werr;
   } err_flags_t;
endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int PW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH+1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full & ~flush;
   assign do_pop  = pop & ~empty & ~flush;

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign count = cnt;
endmodule

// File: rtl/uart_rb_err.sv
module uart_rb_err
   import uart_rb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       par_set,
   input  logic       frm_set,
   input  logic       werr_set,
   output err_flags_t flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (clr) begin
         flags <= '0;
      end else begin
         if (par_set)  flags.par  <= 1'b1;
         if (frm_set)  flags.frm  <= 1'b1;
         if (werr_set) flags.werr <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
   parameter int CW = 7
) (
   input  logic          rx_ie,
   input  logic          tx_ie,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   input  logic [7:0]    rx_thr,
   input  logic [7:0]    tx_thr,
   output logic          irq
);
   logic rx_hit, tx_hit;

   assign rx_hit = rx_ie && (int'(rx_cnt) >= int'(rx_thr));
   assign tx_hit = tx_ie && (int'(tx_cnt) <  int'(tx_thr));
   assign irq    = rx_hit | tx_hit;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic [7:0]    tx_data,
   output logic          tx_valid,
   input  logic          tx_ready,
   input  logic          tx_busy,
   input  logic [7:0]    rx_data,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic          par_err_in,
   input  logic          frm_err_in,
   output logic [31:0]   cfg_ctrl,
   output logic [31:0]   cfg_baud,
   output logic          irq
);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("DEPTH must lie in 2..255 so that an 8-bit threshold can cover it");
      end
      if (AW < 5) begin : g_bad_aw
         $error("AW must be at least 5 to reach offset 0x14");
      end
   endgenerate

   logic [31:0]   ctrl_q, baud_q, rdata_q;
   logic [15:0]   thr_q;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [7:0]    tx_head, rx_head;
   err_flags_t    errs;

   logic wr_txd, wr_ctrl, wr_thr, wr_baud, rd_rxd;
   logic tx_pop, rx_push;

   assign wr_txd  = bus_wr && (bus_addr == AW'(OFS_TXD));
   assign wr_ctrl = bus_wr && (bus_addr == AW'(OFS_CTRL));
   assign wr_thr  = bus_wr && (bus_addr == AW'(OFS_THR));
   assign wr_baud = bus_wr && (bus_addr == AW'(OFS_BAUD));
   assign rd_rxd  = bus_rd && (bus_addr == AW'(OFS_RXD));

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         thr_q  <= '0;
         baud_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (wr_thr)  thr_q  <= bus_wdata[15:0];
         if (wr_baud) baud_q <= bus_wdata;
      end
   end

   // transmit path
   assign tx_valid = ~tx_empty & ctrl_q[C_TX_EN] & ~ctrl_q[C_TX_FLUSH];
   assign tx_pop   = tx_valid & tx_ready;
   assign tx_data  = tx_head;

   uart_rb_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (ctrl_q[C_TX_FLUSH]),
      .push  (wr_txd),
      .din   (bus_wdata[7:0]),
      .pop   (tx_pop),
      .dout  (tx_head),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   // receive path
   assign rx_ready = ~rx_full & ctrl_q[C_RX_EN] & ~ctrl_q[C_RX_FLUSH];
   assign rx_push  = rx_valid & rx_ready;

   uart_rb_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (ctrl_q[C_RX_FLUSH]),
      .push  (rx_push),
      .din   (rx_data),
      .pop   (rd_rxd),
      .dout  (rx_head),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // sticky error flags
   uart_rb_err u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctrl_q[C_ERR_CLR]),
      .par_set  (par_err_in),
      .frm_set  (frm_err_in),
      .werr_set (wr_txd & tx_full & ~ctrl_q[C_TX_FLUSH]),
      .flags    (errs)
   );

   // interrupt
   uart_rb_irq #(.CW(CW)) u_irq (
      .rx_ie  (ctrl_q[C_RX_IE]),
      .tx_ie  (ctrl_q[C_TX_IE]),
      .rx_cnt (rx_cnt),
      .tx_cnt (tx_cnt),
      .rx_thr (thr_q[7:0]),
      .tx_thr (thr_q[15:8]),
      .irq    (irq)
   );

   // status word and read mux
   logic [31:0] stat_w;
   always_comb begin
      stat_w             = '0;
      stat_w[S_PAR]      = errs.par;
      stat_w[S_FRM]      = errs.frm;
      stat_w[S_WERR]     = errs.werr;
      stat_w[S_RX_EMPTY] = rx_empty;
      stat_w[S_TX_FULL]  = tx_full;
      stat_w[S_TX_EMPTY] = tx_empty;
      stat_w[S_BUSY]     = tx_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         case (int'(bus_addr))
            OFS_RXD:  rdata_q <= rx_empty ? 32'h0 : {24'h0, rx_head};
            OFS_CTRL: rdata_q <= ctrl_q;
            OFS_STAT: rdata_q <= stat_w;
            OFS_THR:  rdata_q <= {16'h0, thr_q};
            OFS_BAUD: rdata_q <= baud_q;
            default:  rdata_q <= '0;
         endcase
      end
   end

   assign bus_rdata = rdata_q;
   assign cfg_ctrl  = ctrl_q;
   assign cfg_baud  = baud_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int DEPTH = 64,
   parameter int AW    = 5,
   parameter int CW    = $clog2(DEPTH+1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic          rx_ready,
   input logic [31:0]   cfg_ctrl,
   input logic          irq,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          par_q,
   input logic          frm_q,
   input logic          werr_q
);
   logic txd_wr;
   assign txd_wr = bus_wr && (bus_addr == '0);

   p_txvalid_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ctrl[12] |-> !tx_valid);

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

   p_werr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_wr && int'(tx_cnt) == DEPTH && !cfg_ctrl[24] && !cfg_ctrl[22]) |=> werr_q);

   p_rx_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (int'(rx_cnt) < DEPTH && cfg_ctrl[13]));

   p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl[24] |=> (!par_q && !frm_q && !werr_q));

   p_tx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl[22] |=> (tx_cnt == '0));

   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ctrl[27] && !cfg_ctrl[28]) |-> !irq);

   p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && txd_wr && int'(tx_cnt) != DEPTH) |=> $stable(tx_cnt));
endmodule

bind uart_regbank uart_regbank_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rx_ready (rx_ready),
   .cfg_ctrl (cfg_ctrl),
   .irq      (irq),
   .tx_cnt   (tx_cnt),
   .rx_cnt   (rx_cnt),
   .par_q    (errs.par),
   .frm_q    (errs.frm),
   .werr_q   (errs.werr)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
   localparam int DEPTH = 64;
   localparam int AW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [7:0]    tx_data;
   logic          tx_valid;
   logic          tx_ready = 1'b0, tx_busy = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          rx_valid = 1'b0;
   logic          rx_ready;
   logic          par_err_in = 1'b0, frm_err_in = 1'b0;
   logic [31:0]   cfg_ctrl, cfg_baud;
   logic          irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] ctrl_sh = '0;

   always #4 clk = ~clk;

   uart_regbank #(.DEPTH(DEPTH), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_busy(tx_busy),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .par_err_in(par_err_in), .frm_err_in(frm_err_in),
      .cfg_ctrl(cfg_ctrl), .cfg_baud(cfg_baud), .irq(irq)
   );

   // {fill, tx threshold, expected irq}
   localparam logic [16:0] VEC [6] = '{
      {8'd0,  8'd0,  1'b0},
      {8'd0,  8'd1,  1'b1},
      {8'd3,  8'd3,  1'b0},
      {8'd2,  8'd3,  1'b1},
      {8'd5,  8'd8,  1'b1},
      {8'd64, 8'd64, 1'b0}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = AW'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_ctrl(logic [31:0] v);
      ctrl_sh = v;
      wr('h08, v);
   endtask

   task automatic flush_tx();
      set_ctrl(ctrl_sh | 32'h0040_0000);
      set_ctrl(ctrl_sh & ~32'h0040_0000);
   endtask

   task automatic tx_take(output logic [7:0] b);
      b = tx_data;
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic rx_give(logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_err(bit par);
      @(negedge clk);
      if (par) par_err_in = 1'b1; else frm_err_in = 1'b1;
      @(negedge clk);
      par_err_in = 1'b0; frm_err_in = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd('h0C, v); check("R1 status", v, 32'h0050_0000);
      rd('h08, v); check("R1 ctrl", v, 0);
      rd('h10, v); check("R1 thr", v, 0);
      rd('h14, v); check("R1 baud", v, 0);
      check("R1 irq", {31'b0, irq}, 0);

      // R2 register readback
      wr('h14, 32'hA5C3_0F1E); rd('h14, v); check("R2 baud", v, 32'hA5C3_0F1E);
      check("R2 cfg_baud", cfg_baud, 32'hA5C3_0F1E);
      wr('h10, 32'hFFFF_1234); rd('h10, v); check("R2 thr upper", v, 32'h0000_1234);
      set_ctrl(32'h0000_0001); rd('h08, v); check("R2 ctrl", v, 32'h1);
      rd('h18, v); check("R2 unmapped", v, 0);
      wr('h10, 0);
      set_ctrl(0);

      // R9 threshold vectors, transmitter disabled so fill stays put
      for (int i = 0; i < 6; i++) begin
         set_ctrl(32'h1000_0000);
         flush_tx();
         for (int k = 0; k < int'(VEC[i][16:9]); k++) wr('h00, k);
         wr('h10, {16'h0, VEC[i][8:1], 8'h00});
         check($sformatf("R9 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
      end
      set_ctrl(0); flush_tx(); wr('h10, 0);

      // R3 order and enable gating
      wr('h00, 32'h0000_0111); wr('h00, 32'h22); wr('h00, 32'h33);
      @(negedge clk);
      check("R3 valid gated off", {31'b0, tx_valid}, 0);
      set_ctrl(32'h0000_1000);
      @(negedge clk);
      check("R3 valid on", {31'b0, tx_valid}, 1);
      tx_take(b); check("R3 byte0", b, 8'h11);
      tx_take(b); check("R3 byte1", b, 8'h22);
      tx_take(b); check("R3 byte2", b, 8'h33);
      check("R3 valid after drain", {31'b0, tx_valid}, 0);

      // R10 busy mirror and drained condition
      tx_busy = 1'b1;
      rd('h0C, v); check("R10 busy set", v & 32'h0240_0000, 32'h0240_0000);
      tx_busy = 1'b0;
      rd('h0C, v); check("R10 drained", v & 32'h0240_0000, 32'h0040_0000);

      // R4 full and overflow
      set_ctrl(0);
      for (int k = 0; k < DEPTH; k++) wr('h00, k);
      rd('h0C, v); check("R4 full no err", v & 32'h0024_0000, 32'h0020_0000);
      wr('h00, 32'hEE);
      rd('h0C, v); check("R4 werr set", v & 32'h0024_0000, 32'h0024_0000);
      set_ctrl(32'h0000_1000);
      begin
         int bad = 0;
         for (int k = 0; k < DEPTH; k++) begin
            tx_take(b);
            if (b != 8'(k)) bad++;
         end
         check("R4 contents kept", bad, 0);
      end
      rd('h0C, v); check("R4 empty after drain", v & 32'h0040_0000, 32'h0040_0000);

      // R11 transmit push and pop in one cycle
      set_ctrl(0);
      wr('h00, 32'hA1); wr('h00, 32'hA2);
      set_ctrl(32'h0000_1000);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = '0; bus_wdata = 32'hA3; tx_ready = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tx_ready = 1'b0;
      tx_take(b); check("R11 tx second", b, 8'hA2);
      tx_take(b); check("R11 tx third", b, 8'hA3);
      check("R11 tx empty", {31'b0, tx_valid}, 0);

      // R6 sticky errors and clear
      pulse_err(1'b1);
      rd('h0C, v); check("R6 parity sticky", v & 32'h0007_0000, 32'h0005_0000);
      pulse_err(1'b0);
      rd('h0C, v); check("R6 frame sticky", v & 32'h0007_0000, 32'h0007_0000);
      set_ctrl(ctrl_sh | 32'h0100_0000);
      pulse_err(1'b1);
      rd('h0C, v); check("R6 clear holds", v & 32'h0007_0000, 0);
      set_ctrl(ctrl_sh & ~32'h0100_0000);
      rd('h0C, v); check("R6 stays clear", v & 32'h0007_0000, 0);
      pulse_err(1'b0);
      rd('h0C, v); check("R6 frame again", v & 32'h0007_0000, 32'h0002_0000);
      set_ctrl(ctrl_sh | 32'h0100_0000); set_ctrl(ctrl_sh & ~32'h0100_0000);

      // R5 receive path
      set_ctrl(32'h0000_2000);
      @(negedge clk);
      check("R5 rx_ready", {31'b0, rx_ready}, 1);
      rx_give(8'h5A); rx_give(8'h6B);
      rd('h04, v); check("R5 first", v, 32'h5A);
      rd('h04, v); check("R5 second", v, 32'h6B);
      rd('h04, v); check("R5 empty read", v, 0);
      rd('h0C, v); check("R5 still empty", v & 32'h0010_0000, 32'h0010_0000);

      // R11 receive push and read in one cycle
      rx_give(8'h71);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h72; bus_rd = 1'b1; bus_addr = AW'('h04);
      @(negedge clk);
      rx_valid = 1'b0; bus_rd = 1'b0;
      check("R11 rx head", bus_rdata, 32'h71);
      rd('h04, v); check("R11 rx next", v, 32'h72);
      rd('h0C, v); check("R11 rx empty", v & 32'h0010_0000, 32'h0010_0000);

      // R8 receive interrupt
      wr('h10, 32'h0000_0002);
      set_ctrl(32'h0800_2000);
      rx_give(8'h01);
      check("R8 below thr", {31'b0, irq}, 0);
      rx_give(8'h02);
      check("R8 at thr", {31'b0, irq}, 1);
      rd('h04, v);
      check("R8 after read", {31'b0, irq}, 0);

      // R7 receive flush holds FIFO empty
      set_ctrl(ctrl_sh | 32'h0080_0000);
      check("R7 rx_ready off", {31'b0, rx_ready}, 0);
      rx_give(8'h99);
      rd('h0C, v); check("R7 rx held empty", v & 32'h0010_0000, 32'h0010_0000);
      set_ctrl(ctrl_sh & ~32'h0080_0000);
      rx_give(8'h44);
      rd('h04, v); check("R7 rx usable", v, 32'h44);

      // R7 transmit flush
      set_ctrl(32'h0040_0000);
      wr('h00, 32'h55);
      rd('h0C, v); check("R7 tx held empty", v & 32'h0040_0000, 32'h0040_0000);
      set_ctrl(0);
      wr('h00, 32'h56);
      set_ctrl(32'h0000_1000);
      @(negedge clk);
      tx_take(b); check("R7 tx usable", b, 8'h56);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule